// File: doc/BRIEF.md
# Downstream Port Attach/Detach Detector

This block observes the two single-ended receiver levels of one downstream bus port. It decides when a device has attached and when it has gone away. A device that pulls D+ high while D- stays low is treated as full- or high-speed. A device that pulls D- high while D+ stays low is treated as low-speed. A port whose two lines both sit low, a single-ended zero, has nothing attached.

Each decision is debounced before it is reported. The line state has to stay unchanged across a run of timebase ticks. The attach run and the detach run have separate lengths. An attach needs at least 2.5 µs of stable line state. A detach needs a single-ended zero that lasts between 2.0 µs and 2.5 µs. Reporting an attach later than the minimum is allowed, up to a limit of two seconds, so the attach run can be rounded up freely. The detach run has to fall inside its narrow band. The timebase tick is an input, so the tick counts `CONN_TICKS` and `DISC_TICKS` are chosen together with the tick period. With a 0.5 µs tick, the defaults give a 3.0 µs attach run and a detach run of 2.0 to 2.5 µs.

The port-enable input gates everything. While it is low, the detector forgets any attachment and reports nothing.

Top module: `port_attach_detect`

## Requirements
- R1: After reset, `connected`, `lowSpeed`, `connChange` and `discPulse` are all 0.
- R2: While detached and enabled, a line state of D+=1, D-=0 held unchanged for `CONN_TICKS` sampled ticks sets `connected` to 1 with `lowSpeed` at 0. The change happens at the clock edge that samples the final tick, so the new value is seen right after that edge.
- R3: While detached and enabled, a line state of D+=0, D-=1 held unchanged for `CONN_TICKS` ticks sets `connected` to 1 with `lowSpeed` at 1.
- R4: `connChange` is a pulse of exactly one clock cycle at each reported attach and each reported detach. At all other times it is 0.
- R5: While connected and enabled, D+=0 and D-=0 held for `DISC_TICKS` ticks clears `connected` and `lowSpeed`. In that same cycle, `discPulse` and `connChange` are both 1 for exactly one clock.
- R6: Any change of the sampled line state restarts the current debounce run. A run that stops one tick short, or that is broken by a change, reports no event.
- R7: D+=1 with D-=1 never counts toward an attach. While connected, any line state other than a single-ended zero clears the detach run.
- R8: While `portEn` is 0, `connected` and `lowSpeed` are 0 from the next clock on, no pulse is raised, and both runs are cleared. After the port is enabled again, an attach needs a fresh full run.
- R9: `lowSpeed` keeps the class captured at attach time for as long as the device stays connected, whatever line traffic follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| portEn | input | 1 | Port enable; when low, the detector is cleared and silent |
| tick | input | 1 | One-cycle timebase strobe that advances the debounce runs |
| dpLevel | input | 1 | Synchronized D+ single-ended receiver level |
| dmLevel | input | 1 | Synchronized D- single-ended receiver level |
| connected | output | 1 | A device is attached |
| lowSpeed | output | 1 | The attached device is low-speed |
| connChange | output | 1 | One-cycle pulse when `connected` changes through detection |
| discPulse | output | 1 | One-cycle pulse when a detach is reported |

## Verification
The line levels pass through two register stages before the change detector settles. A new line value therefore affects counting from the third clock edge after it is driven. The bench always waits two idle cycles after driving a line value and only then raises a tick.

All results, the status bits as well as both pulses, update at the edge that samples the completing tick. The bench checks them at the falling edge right after that tick. It then checks during the idle cycles of the next step that the pulses have dropped.

A disable takes effect at the first edge after `portEn` falls. The bench therefore checks the cleared status one cycle after it lowers the enable.

// File: rtl/port_attach_pkg.sv
package port_attach_pkg;

  typedef enum logic [1:0] {
    LINE_SE0  = 2'b00,
    LINE_LOW  = 2'b01,
    LINE_FULL = 2'b10,
    LINE_SE1  = 2'b11
  } lineClass_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic selDisc;
  } ctrlStrobe_t;

endpackage

// File: rtl/port_attach_datapath.sv
module port_attach_datapath
  import port_attach_pkg::*;
#(
  parameter int CONN_TICKS = 6,
  parameter int DISC_TICKS = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dpLevel,
  input  logic        dmLevel,
  input  ctrlStrobe_t strobe,
  output lineClass_t  lineNow,
  output logic        lineChanged,
  output logic        cntHit
);

  localparam int MAX_TICKS = (CONN_TICKS > DISC_TICKS) ? CONN_TICKS : DISC_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] CONN_LAST = CNT_W'(CONN_TICKS - 1);
  localparam logic [CNT_W-1:0] DISC_LAST = CNT_W'(DISC_TICKS - 1);

  logic [1:0]       lineQ;
  logic [1:0]       linePrev;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] runLast;

  // two-stage line capture; the second stage exposes a change for one cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ    <= 2'b00;
      linePrev <= 2'b00;
    end else begin
      lineQ    <= {dpLevel, dmLevel};
      linePrev <= lineQ;
    end
  end

  assign lineNow     = lineClass_t'(lineQ);
  assign lineChanged = (lineQ != linePrev);

  assign runLast = strobe.selDisc ? DISC_LAST : CONN_LAST;
  assign cntHit  = (runCnt == runLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (strobe.cntClear) begin
      runCnt <= '0;
    end else if (strobe.cntInc) begin
      runCnt <= cntHit ? '0 : runCnt + 1'b1;
    end
  end

endmodule

// File: rtl/port_attach_control.sv
module port_attach_control
  import port_attach_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        portEn,
  input  logic        tick,
  input  lineClass_t  lineNow,
  input  logic        lineChanged,
  input  logic        cntHit,
  output ctrlStrobe_t strobe,
  output logic        connected,
  output logic        lowSpeed,
  output logic        connChange,
  output logic        discPulse
);

  logic attached;
  logic lsCaptured;
  logic chgQ;
  logic discQ;
  logic targetSeen;
  logic qualify;
  logic fire;

  always_comb begin
    if (attached) targetSeen = (lineNow == LINE_SE0);
    else          targetSeen = (lineNow == LINE_FULL) || (lineNow == LINE_LOW);
  end

  assign qualify         = portEn && !lineChanged && targetSeen;
  assign strobe.cntClear = !qualify;
  assign strobe.cntInc   = qualify && tick;
  assign strobe.selDisc  = attached;
  assign fire            = strobe.cntInc && cntHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attached   <= 1'b0;
      lsCaptured <= 1'b0;
      chgQ       <= 1'b0;
      discQ      <= 1'b0;
    end else if (!portEn) begin
      attached   <= 1'b0;
      lsCaptured <= 1'b0;
      chgQ       <= 1'b0;
      discQ      <= 1'b0;
    end else begin
      chgQ  <= fire;
      discQ <= fire && attached;
      if (fire) begin
        attached   <= !attached;
        lsCaptured <= !attached && (lineNow == LINE_LOW);
      end
    end
  end

  assign connected  = attached;
  assign lowSpeed   = lsCaptured;
  assign connChange = chgQ;
  assign discPulse  = discQ;

endmodule

// File: rtl/port_attach_detect.sv
module port_attach_detect
  import port_attach_pkg::*;
#(
  parameter int CONN_TICKS = 6,
  parameter int DISC_TICKS = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic portEn,
  input  logic tick,
  input  logic dpLevel,
  input  logic dmLevel,
  output logic connected,
  output logic lowSpeed,
  output logic connChange,
  output logic discPulse
);

  ctrlStrobe_t strobe;
  lineClass_t  lineNow;
  logic        lineChanged;
  logic        cntHit;

  port_attach_datapath #(
    .CONN_TICKS(CONN_TICKS),
    .DISC_TICKS(DISC_TICKS)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .dpLevel    (dpLevel),
    .dmLevel    (dmLevel),
    .strobe     (strobe),
    .lineNow    (lineNow),
    .lineChanged(lineChanged),
    .cntHit     (cntHit)
  );

  port_attach_control uControl (
    .clk        (clk),
    .rstN       (rstN),
    .portEn     (portEn),
    .tick       (tick),
    .lineNow    (lineNow),
    .lineChanged(lineChanged),
    .cntHit     (cntHit),
    .strobe     (strobe),
    .connected  (connected),
    .lowSpeed   (lowSpeed),
    .connChange (connChange),
    .discPulse  (discPulse)
  );

endmodule

// File: rtl/port_attach_sva.sv
module port_attach_sva (
  input logic clk,
  input logic rstN,
  input logic portEn,
  input logic dpLevel,
  input logic dmLevel,
  input logic connected,
  input logic lowSpeed,
  input logic connChange,
  input logic discPulse
);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    connChange |=> !connChange);  // R4

  AST_DISC_WITH_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    discPulse |-> (connChange && !connected));  // R5

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> (!connected && !lowSpeed && !connChange && !discPulse));  // R8

  AST_LS_NEEDS_CONN: assert property (@(posedge clk) disable iff (!rstN)
    lowSpeed |-> connected);  // R9

  AST_ATTACH_LINE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(connected) |-> ($past(dpLevel, 2) != $past(dmLevel, 2)));  // R7

  AST_DETACH_LINE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(connected) && $past(portEn)) |-> (!$past(dpLevel, 2) && !$past(dmLevel, 2)));  // R5

endmodule

bind port_attach_detect port_attach_sva uSva (
  .clk       (clk),
  .rstN      (rstN),
  .portEn    (portEn),
  .dpLevel   (dpLevel),
  .dmLevel   (dmLevel),
  .connected (connected),
  .lowSpeed  (lowSpeed),
  .connChange(connChange),
  .discPulse (discPulse)
);

// File: tb/tb_port_attach_detect.sv
module tb_port_attach_detect;

  localparam int CONN_TICKS = 6;
  localparam int DISC_TICKS = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic portEn = 1'b0;
  logic tick = 1'b0;
  logic dpLevel = 1'b0;
  logic dmLevel = 1'b0;
  logic connected, lowSpeed, connChange, discPulse;

  int checks = 0;
  int errors = 0;

  logic [1:0] curLine = 2'b00;
  logic       mAtt = 1'b0;
  logic       mLs = 1'b0;
  int         run = 0;

  always #10 clk = ~clk;

  port_attach_detect #(.CONN_TICKS(CONN_TICKS), .DISC_TICKS(DISC_TICKS)) dut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .tick(tick),
    .dpLevel(dpLevel), .dmLevel(dmLevel),
    .connected(connected), .lowSpeed(lowSpeed),
    .connChange(connChange), .discPulse(discPulse)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic isTarget(input logic att, input logic [1:0] ln);
    if (att) return (ln == 2'b00);
    return (ln == 2'b10) || (ln == 2'b01);
  endfunction

  // one stimulus step: drive line and enable, settle two cycles, then one tick
  task automatic doStep(input logic [1:0] ln, input logic en, input string req);
    logic evt;
    logic wasAtt;
    @(negedge clk);
    if (ln != curLine) run = 0;
    curLine = ln;
    {dpLevel, dmLevel} = ln;
    portEn = en;
    if (!en) begin
      mAtt = 1'b0; mLs = 1'b0; run = 0;
    end
    @(negedge clk);
    chk(connChange, 1'b0, "R4", "connChange idle");
    if (!en) chk(connected, 1'b0, "R8", "connected while disabled");
    @(negedge clk);
    chk(connChange, 1'b0, "R4", "connChange idle");
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    evt = 1'b0;
    wasAtt = mAtt;
    if (en) begin
      if (isTarget(mAtt, ln)) begin
        run++;
        if (run == (mAtt ? DISC_TICKS : CONN_TICKS)) begin
          evt = 1'b1;
          run = 0;
          mLs = !mAtt && (ln == 2'b01);
          mAtt = !mAtt;
        end
      end else begin
        run = 0;
      end
    end
    chk(connChange, evt, req, "connChange");
    chk(discPulse, evt && wasAtt, req, "discPulse");
    chk(connected, mAtt, req, "connected");
    chk(lowSpeed, mLs, req, "lowSpeed");
  endtask

  task automatic repeatStep(input int n, input logic [1:0] ln, input string req);
    for (int i = 0; i < n; i++) doStep(ln, 1'b1, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] rl;
    logic       re;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(connected, 1'b0, "R1", "connected reset");
    chk(lowSpeed, 1'b0, "R1", "lowSpeed reset");
    chk(connChange, 1'b0, "R1", "connChange reset");
    chk(discPulse, 1'b0, "R1", "discPulse reset");
    rstN = 1'b1;

    // R2 full-speed attach: one tick short gives nothing, then it fires
    repeatStep(CONN_TICKS - 1, 2'b10, "R2");
    chk(connected, 1'b0, "R6", "one tick short");
    doStep(2'b10, 1'b1, "R2");
    chk(connected, 1'b1, "R2", "full-speed attached");
    // R7/R9 traffic while connected does not detach or change class
    repeatStep(3, 2'b01, "R9");
    repeatStep(2, 2'b11, "R7");
    repeatStep(DISC_TICKS - 1, 2'b00, "R7");
    doStep(2'b10, 1'b1, "R7");
    chk(connected, 1'b1, "R7", "interrupted detach");
    // R5 detach
    repeatStep(DISC_TICKS, 2'b00, "R5");
    chk(connected, 1'b0, "R5", "detached");
    // R3 low-speed attach after an interrupted run (R6)
    repeatStep(3, 2'b01, "R6");
    doStep(2'b10, 1'b1, "R6");
    repeatStep(CONN_TICKS, 2'b01, "R3");
    chk(lowSpeed, 1'b1, "R3", "low-speed class");
    repeatStep(2, 2'b10, "R9");
    // R8 disable clears, re-enable needs a fresh run
    doStep(2'b01, 1'b0, "R8");
    repeatStep(CONN_TICKS - 1, 2'b01, "R8");
    chk(connected, 1'b0, "R8", "fresh run needed");
    doStep(2'b01, 1'b1, "R8");
    // R7 SE1 never attaches
    repeatStep(DISC_TICKS, 2'b00, "R5");
    repeatStep(CONN_TICKS + 2, 2'b11, "R7");

    for (int i = 0; i < 600; i++) begin
      rl = ($urandom_range(0, 99) < 85) ? curLine : 2'($urandom_range(0, 3));
      re = ($urandom_range(0, 99) < 97);
      doStep(rl, re, "R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule